// File: doc/BRIEF.md
# Four-Phase Handshaked Word Link

This block carries one 32-bit word, made of four bytes, from a sending clock domain to a receiving clock domain that runs at an unrelated frequency. The two sides agree on each transfer through level flags. The sender raises a request and holds the word. The receiver marks itself busy, has the word judged by an external check, keeps the word if the check passes, and posts a pass or reject verdict. The sender then drops its request and raises a receipt flag. Each side puts its flags back to idle only after it sees the other side's answer, so every transfer is a full four-phase exchange.

On the sending side, a word is offered with a one-cycle start pulse. The block reports the end of a transfer with a one-cycle done pulse that carries either a success flag or a hard-failure flag. A rejected word is offered again automatically, up to a fixed number of attempts. On the receiving side, the block shows each candidate word with a strobe, takes the pass/reject answer in the same cycle, and emits a store strobe for each word it accepts. Every flag that crosses between the domains goes through a multi-flop synchronizer. The receiver will not act on a request until it has seen the request low at least once after its own reset, so a request left over from start-up cannot start a transfer.

Top module: `hsl_word_link`

## Requirements
- R1: After the receiver leaves reset, it raises no `chk_stb` until it has observed the sender's request low at least once. A request that is already high when the receiver starts up is never evaluated.
- R2: `tx_start` is taken only in a cycle where `tx_ready` is 1. `tx_ready` falls in the cycle after a start is taken. A `tx_start` pulse given while a transfer is in progress has no effect on the word evaluated or stored, and it adds no transfer.
- R3: Each attempt yields exactly one single-cycle `chk_stb`. `chk_word` during that strobe equals the word that was accepted at the start.
- R4: `st_stb` is a single-cycle pulse. It comes one receiver cycle after a `chk_stb` cycle in which `chk_pass` was 1, and `st_word` then equals the evaluated word. A rejected attempt gives no `st_stb`.
- R5: When an attempt passes, the sender gives one single-cycle `tx_done` with `tx_ok`=1 and `tx_hard_fail`=0.
- R6: After a rejected attempt, the same word is offered again. If the word passes on attempt k, with k at most 3, exactly k strobes appear on `chk_stb` for that transfer.
- R7: After 3 rejected attempts, the sender gives `tx_done` with `tx_ok`=0 and `tx_hard_fail`=1. It makes no further attempt and stores nothing. `tx_ok` and `tx_hard_fail` are 0 whenever `tx_done` is 0.
- R8: Every word whose transfer ends with `tx_ok`=1 is stored exactly once, and in start order.
- R9: After both sides leave reset with no transfer pending, `tx_ready` returns to 1 and `tx_done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_s | input | 1 | Sender clock |
| rst_s_n | input | 1 | Sender asynchronous reset, active low |
| tx_start | input | 1 | Start pulse; the word on `tx_word` is taken when `tx_ready` is 1 |
| tx_word | input | 32 | Word to transfer |
| tx_ready | output | 1 | Sender is idle and sees every receiver flag low |
| tx_done | output | 1 | One-cycle pulse at the end of a transfer |
| tx_ok | output | 1 | With `tx_done`: the word was accepted |
| tx_hard_fail | output | 1 | With `tx_done`: every attempt was rejected |
| clk_r | input | 1 | Receiver clock |
| rst_r_n | input | 1 | Receiver asynchronous reset, active low |
| chk_word | output | 32 | Word being evaluated |
| chk_stb | output | 1 | Evaluation strobe; `chk_pass` is sampled in this cycle |
| chk_pass | input | 1 | Verdict of the external check for `chk_word` |
| st_word | output | 32 | Accepted word |
| st_stb | output | 1 | One-cycle strobe for each accepted word |

## Verification
The case that is hardest to reach from the ports is a request that is already high when the receiver comes out of reset. To create it, the bench holds the receiver in reset, starts a transfer on the sender, releases the receiver, and confirms that no evaluation follows. It then resets the sender to drop the request and checks that later transfers run normally. The retry path depends on verdicts that change across attempts. The bench's check model therefore rejects each word as many times as the value of its two low bits. This covers a pass on the first, second and third attempt, as well as the hard failure. Both clocks run at unrelated periods, and a start pulse is also injected in the middle of a transfer.

// File: rtl/hsl_pkg.sv
package hsl_pkg;
   typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_ACK, TX_RELAUNCH} tx_state_e;
   typedef enum logic [1:0] {RX_IDLE, RX_CHECK, RX_POST} rx_state_e;
endpackage

// File: rtl/hsl_sync.sv
module hsl_sync #(
   parameter int              STAGES  = 2,
   parameter int              WIDTH   = 1,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int CHAIN_W = STAGES * WIDTH;

   logic [CHAIN_W-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hsl_sync: STAGES must be at least 2");
      end
   endgenerate

   // Reset loads RST_VAL into every stage so that q shows a chosen safe value
   // until the real level has passed through the chain.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[CHAIN_W-WIDTH-1:0], d};
   end

   assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/hsl_tx.sv
module hsl_tx
   import hsl_pkg::*;
#(
   parameter int W         = 32,
   parameter int MAX_TRIES = 3,
   parameter int CNT_W     = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] word_in,
   output logic         ready,
   output logic         done,
   output logic         ok,
   output logic         hard_fail,
   output logic         req,
   output logic         rcvd,
   output logic [W-1:0] word_out,
   input  logic         busy_i,
   input  logic         ok_i,
   input  logic         err_i
);
   tx_state_e        state;
   logic [CNT_W-1:0] tries;
   logic             verdict_ok;
   logic [W-1:0]     word_q;
   logic             peer_idle;

   assign peer_idle = !busy_i && !ok_i && !err_i;
   assign ready     = (state == TX_IDLE) && peer_idle;
   assign word_out  = word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= TX_IDLE;
         tries      <= '0;
         verdict_ok <= 1'b0;
         word_q     <= '0;
         req        <= 1'b0;
         rcvd       <= 1'b0;
         done       <= 1'b0;
         ok         <= 1'b0;
         hard_fail  <= 1'b0;
      end else begin
         done      <= 1'b0;
         ok        <= 1'b0;
         hard_fail <= 1'b0;
         case (state)
            TX_IDLE: begin
               if (start && peer_idle) begin
                  word_q <= word_in;
                  tries  <= CNT_W'(1);
                  req    <= 1'b1;
                  state  <= TX_WAIT;
               end
            end
            TX_WAIT: begin
               // While busy is up, nothing moves; a verdict ends the wait.
               if (!busy_i && (ok_i || err_i)) begin
                  req        <= 1'b0;
                  rcvd       <= 1'b1;
                  verdict_ok <= ok_i;
                  state      <= TX_ACK;
               end
            end
            TX_ACK: begin
               if (!ok_i && !err_i) begin
                  rcvd <= 1'b0;
                  if (verdict_ok) begin
                     done  <= 1'b1;
                     ok    <= 1'b1;
                     state <= TX_IDLE;
                  end else if (tries == CNT_W'(MAX_TRIES)) begin
                     done      <= 1'b1;
                     hard_fail <= 1'b1;
                     state     <= TX_IDLE;
                  end else begin
                     tries <= tries + 1'b1;
                     state <= TX_RELAUNCH;
                  end
               end
            end
            TX_RELAUNCH: begin
               req   <= 1'b1;
               state <= TX_WAIT;
            end
            default: state <= TX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hsl_rx.sv
module hsl_rx
   import hsl_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req_i,
   input  logic         rcvd_i,
   input  logic [W-1:0] word_i,
   output logic         busy,
   output logic         ok,
   output logic         err,
   output logic [W-1:0] chk_word,
   output logic         chk_stb,
   input  logic         chk_pass,
   output logic [W-1:0] st_word,
   output logic         st_stb
);
   rx_state_e    state;
   logic         armed;
   logic [W-1:0] word_q;

   assign chk_stb  = (state == RX_CHECK);
   assign chk_word = word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RX_IDLE;
         armed   <= 1'b0;
         word_q  <= '0;
         busy    <= 1'b0;
         ok      <= 1'b0;
         err     <= 1'b0;
         st_word <= '0;
         st_stb  <= 1'b0;
      end else begin
         st_stb <= 1'b0;
         if (!req_i) armed <= 1'b1;
         case (state)
            RX_IDLE: begin
               if (armed && req_i && !rcvd_i) begin
                  busy   <= 1'b1;
                  word_q <= word_i;   // held stable by the sender while req is up
                  state  <= RX_CHECK;
               end
            end
            RX_CHECK: begin
               busy <= 1'b0;
               ok   <= chk_pass;
               err  <= !chk_pass;
               if (chk_pass) begin
                  st_word <= word_q;
                  st_stb  <= 1'b1;
               end
               state <= RX_POST;
            end
            RX_POST: begin
               if (!req_i && rcvd_i) begin
                  ok    <= 1'b0;
                  err   <= 1'b0;
                  state <= RX_IDLE;
               end
            end
            default: state <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hsl_word_link.sv
module hsl_word_link #(
   parameter int BYTE_W      = 8,
   parameter int N_BYTES     = 4,
   parameter int MAX_TRIES   = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                      clk_s,
   input  logic                      rst_s_n,
   input  logic                      tx_start,
   input  logic [BYTE_W*N_BYTES-1:0] tx_word,
   output logic                      tx_ready,
   output logic                      tx_done,
   output logic                      tx_ok,
   output logic                      tx_hard_fail,
   input  logic                      clk_r,
   input  logic                      rst_r_n,
   output logic [BYTE_W*N_BYTES-1:0] chk_word,
   output logic                      chk_stb,
   input  logic                      chk_pass,
   output logic [BYTE_W*N_BYTES-1:0] st_word,
   output logic                      st_stb
);
   localparam int W     = BYTE_W * N_BYTES;
   localparam int CNT_W = $clog2(MAX_TRIES + 1);

   generate
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("hsl_word_link: MAX_TRIES must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("hsl_word_link: SYNC_STAGES must be at least 2");
      end
      if (N_BYTES < 1 || BYTE_W < 1) begin : g_bad_width
         $error("hsl_word_link: word must be at least one bit");
      end
   endgenerate

   logic         req_s, rcvd_s;
   logic [W-1:0] word_s;
   logic         busy_r, ok_r, err_r;
   logic [2:0]   flags_at_s;
   logic [1:0]   flags_at_r;

   // Receiver flags seen by the sender reset to "busy" so that no start is
   // taken before the real levels have crossed.
   hsl_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b111)) u_sync_to_s (
      .clk(clk_s), .rst_n(rst_s_n), .d({busy_r, ok_r, err_r}), .q(flags_at_s)
   );

   // Request seen by the receiver resets to high so that arming needs a real low.
   hsl_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(2'b01)) u_sync_to_r (
      .clk(clk_r), .rst_n(rst_r_n), .d({rcvd_s, req_s}), .q(flags_at_r)
   );

   hsl_tx #(.W(W), .MAX_TRIES(MAX_TRIES), .CNT_W(CNT_W)) u_tx (
      .clk(clk_s), .rst_n(rst_s_n),
      .start(tx_start), .word_in(tx_word),
      .ready(tx_ready), .done(tx_done), .ok(tx_ok), .hard_fail(tx_hard_fail),
      .req(req_s), .rcvd(rcvd_s), .word_out(word_s),
      .busy_i(flags_at_s[2]), .ok_i(flags_at_s[1]), .err_i(flags_at_s[0])
   );

   hsl_rx #(.W(W)) u_rx (
      .clk(clk_r), .rst_n(rst_r_n),
      .req_i(flags_at_r[0]), .rcvd_i(flags_at_r[1]), .word_i(word_s),
      .busy(busy_r), .ok(ok_r), .err(err_r),
      .chk_word(chk_word), .chk_stb(chk_stb), .chk_pass(chk_pass),
      .st_word(st_word), .st_stb(st_stb)
   );
endmodule

// File: rtl/hsl_word_link_chk.sv
module hsl_word_link_chk (
   input logic clk_s,
   input logic rst_s_n,
   input logic tx_start,
   input logic tx_ready,
   input logic tx_done,
   input logic tx_ok,
   input logic tx_hard_fail,
   input logic clk_r,
   input logic rst_r_n,
   input logic chk_stb,
   input logic chk_pass,
   input logic st_stb
);
   assert_ready_drops_R2: assert property (@(posedge clk_s) disable iff (!rst_s_n)
      (tx_start && tx_ready) |=> !tx_ready);

   assert_chk_single_R3: assert property (@(posedge clk_r) disable iff (!rst_r_n)
      chk_stb |=> !chk_stb);

   assert_store_after_pass_R4: assert property (@(posedge clk_r) disable iff (!rst_r_n)
      st_stb |-> ($past(chk_stb) && $past(chk_pass)));

   assert_store_single_R4: assert property (@(posedge clk_r) disable iff (!rst_r_n)
      st_stb |=> !st_stb);

   assert_done_single_R5: assert property (@(posedge clk_s) disable iff (!rst_s_n)
      tx_done |=> !tx_done);

   assert_done_status_R7: assert property (@(posedge clk_s) disable iff (!rst_s_n)
      tx_done |-> (tx_ok != tx_hard_fail));

   assert_status_quiet_R7: assert property (@(posedge clk_s) disable iff (!rst_s_n)
      !tx_done |-> (!tx_ok && !tx_hard_fail));
endmodule

bind hsl_word_link hsl_word_link_chk u_chk (
   .clk_s(clk_s), .rst_s_n(rst_s_n), .tx_start(tx_start), .tx_ready(tx_ready),
   .tx_done(tx_done), .tx_ok(tx_ok), .tx_hard_fail(tx_hard_fail),
   .clk_r(clk_r), .rst_r_n(rst_r_n), .chk_stb(chk_stb), .chk_pass(chk_pass),
   .st_stb(st_stb)
);

// File: tb/hsl_word_link_tb.sv
module hsl_word_link_tb;
   localparam int CLK_PERIOD   = 10;
   localparam int RX_PERIOD    = 14;
   localparam int WATCHDOG_CYC = 150000;

   logic        clk_s = 1'b0, clk_r = 1'b0;
   logic        rst_s_n = 1'b0, rst_r_n = 1'b0;
   logic        tx_start = 1'b0;
   logic [31:0] tx_word = '0;
   logic        tx_ready, tx_done, tx_ok, tx_hard_fail;
   logic [31:0] chk_word, st_word;
   logic        chk_stb, chk_pass, st_stb;

   int checks = 0, failures = 0;
   int total_chk = 0, base_chk = 0;
   int st_cnt = 0, done_cnt = 0, word_mismatch = 0;
   logic [31:0] last_st = '0, cur_word = '0;

   always #(CLK_PERIOD/2) clk_s = ~clk_s;
   always #(RX_PERIOD/2)  clk_r = ~clk_r;

   hsl_word_link u_dut (
      .clk_s(clk_s), .rst_s_n(rst_s_n), .tx_start(tx_start), .tx_word(tx_word),
      .tx_ready(tx_ready), .tx_done(tx_done), .tx_ok(tx_ok), .tx_hard_fail(tx_hard_fail),
      .clk_r(clk_r), .rst_r_n(rst_r_n), .chk_word(chk_word), .chk_stb(chk_stb),
      .chk_pass(chk_pass), .st_word(st_word), .st_stb(st_stb)
   );

   // Check model: a word is rejected as many times as its two low bits say.
   assign chk_pass = ((total_chk - base_chk) >= int'(chk_word[1:0]));

   always @(posedge clk_r) begin
      if (chk_stb) begin
         total_chk <= total_chk + 1;
         if (chk_word !== cur_word) word_mismatch <= word_mismatch + 1;
      end
      if (st_stb) begin
         st_cnt  <= st_cnt + 1;
         last_st <= st_word;
      end
   end

   always @(posedge clk_s) if (tx_done) done_cnt <= done_cnt + 1;

   task automatic check(input bit cond, input string rq, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!cond) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   task automatic wait_ready(output bit ok_o);
      ok_o = 1'b0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk_s);
         if (tx_ready) begin ok_o = 1'b1; break; end
      end
   endtask

   // Sends one word; inject adds a stray start with another word mid-transfer.
   task automatic send(input logic [31:0] w, input bit inject);
      bit rdy, seen;
      int fails, exp_att, st0, dn0;
      logic got_ok, got_hard;
      fails   = int'(w[1:0]);
      exp_att = (fails < 3) ? fails + 1 : 3;
      wait_ready(rdy);
      check(rdy, "R9", "ready before start", 0, 1);
      base_chk = total_chk;
      st0      = st_cnt;
      dn0      = done_cnt;
      cur_word = w;
      tx_word  = w;
      tx_start = 1'b1;
      @(negedge clk_s);
      tx_start = 1'b0;
      check(!tx_ready, "R2", "ready after start", tx_ready, 0);
      if (inject) begin
         repeat (3) @(negedge clk_s);
         tx_word  = ~w;
         tx_start = 1'b1;
         @(negedge clk_s);
         tx_start = 1'b0;
      end
      seen = 1'b0; got_ok = 1'b0; got_hard = 1'b0;
      for (int i = 0; i < 3000; i++) begin
         if (tx_done) begin seen = 1'b1; got_ok = tx_ok; got_hard = tx_hard_fail; break; end
         @(negedge clk_s);
      end
      check(seen, "R5", "done seen", seen, 1);
      if (fails < 3) begin
         check(got_ok && !got_hard, "R5", "ok status", {got_ok, got_hard}, 2);
         check(st_cnt == st0 + 1, "R8", "stored once", st_cnt - st0, 1);
         check(last_st == w, "R4", "stored word", last_st, w);
      end else begin
         check(!got_ok && got_hard, "R7", "hard fail status", {got_ok, got_hard}, 1);
         check(st_cnt == st0, "R7", "nothing stored", st_cnt - st0, 0);
      end
      check(total_chk - base_chk == exp_att, "R6", "attempt count",
            total_chk - base_chk, exp_att);
      repeat (2) @(negedge clk_s);
      check(done_cnt == dn0 + 1, "R2", "single done", done_cnt - dn0, 1);
   endtask

   initial begin
      int cyc = 0;
      while (cyc < WATCHDOG_CYC) begin
         @(posedge clk_s);
         cyc++;
      end
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      summary();
      $finish;
   end

   initial begin
      bit rdy;
      logic [31:0] w;
      // Sender out of reset first; receiver held in reset.
      repeat (4) @(negedge clk_s);
      rst_s_n = 1'b1;
      repeat (4) @(negedge clk_s);
      check(tx_done == 1'b0, "R9", "done idle after reset", tx_done, 0);
      wait_ready(rdy);
      check(rdy, "R9", "ready after reset", tx_ready, 1);
      // Launch a request the receiver must not act on (R1).
      cur_word = 32'hDEAD_BEE0;
      tx_word  = 32'hDEAD_BEE0;
      tx_start = 1'b1;
      @(negedge clk_s);
      tx_start = 1'b0;
      repeat (20) @(negedge clk_s);
      rst_r_n = 1'b1;
      repeat (80) @(negedge clk_s);
      check(total_chk == 0, "R1", "no evaluation of stale request", total_chk, 0);
      check(st_cnt == 0, "R1", "no store of stale request", st_cnt, 0);
      // Drop the stale request by resetting the sender.
      rst_s_n = 1'b0;
      repeat (3) @(negedge clk_s);
      rst_s_n = 1'b1;
      repeat (10) @(negedge clk_s);
      check(total_chk == 0, "R1", "still no evaluation", total_chk, 0);

      // Sweep: every retry count, many payloads.
      for (int i = 0; i < 24; i++) begin
         w = (32'(i + 1) * 32'h9E37_79B9) & 32'hFFFF_FFFC;
         w = w | 32'(i % 4);
         send(w, (i % 5) == 2);
      end
      check(word_mismatch == 0, "R3", "evaluated word matches", word_mismatch, 0);
      check(st_cnt == 18, "R8", "total stored", st_cnt, 18);
      check(done_cnt == 24, "R5", "total done", done_cnt, 24);
      summary();
      $finish;
   end
endmodule